// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

The block runs on the master clock and counts master-clock cycles between successive rising edges of a frame clock. The frame clock arrives already sampled into the master-clock domain. The frame clock runs at the sample rate, and the two clocks are synchronous, so one period holds a whole number of master cycles. The block checks that count against the ratios allowed by the selected speed band. When the same allowed count appears twice in a row, the block reports the ratio, a divider select and a locked flag. A count that no ratio matches raises an error flag, and the last good setting is kept.

The speed band and the extra-divide enable are watched on every cycle. Any change in them drops the current result and starts the measurement again. The largest ratio of each band is accepted only while the extra divide is enabled. A frame clock that stops cannot wrap the counter, because the counter saturates and the saturated count is reported as an error.

Top module: `ratio_detect`

## Requirements
- R1: A period is the number of master cycles from one sampled rising edge of `fclk_i` to the next. Exact counts only are matched. Ratio codes are 0..8 for 64, 96, 128, 192, 256, 384, 512, 768 and 1024, and 15 means none.
- R2: With `speed_i`=0 (single), the accepted counts are 256, 384, 512 and 768. `div_sel_o` equals the ratio code minus 4.
- R3: With `speed_i`=1 (double), the accepted counts are 128, 192, 256 and 384. `div_sel_o` equals the ratio code minus 2.
- R4: With `speed_i`=2 (quad), the accepted counts are 64, 96, 128 and 192. `div_sel_o` equals the ratio code minus 0. The divider codes 0,1,2,3,4 stand for 1x, 1.5x, 2x, 3x and 4x of the band's smallest ratio.
- R5: The count four times the band's smallest ratio (1024, 512 or 256) is accepted with `div_sel_o`=4 only while `div_en_i`=1. Otherwise it is an error.
- R6: After reset or a mode change, the first rising edge only starts measurement. The partial period before it is never evaluated.
- R7: `locked_o` rises on the edge that ends the second consecutive equal accepted count, and `ratio_o`/`div_sel_o` update at the same time. An accepted count that differs from the previous one clears `locked_o` and keeps both outputs.
- R8: An edge that ends a count with no accepted match sets `err_o` and clears `locked_o`, and `ratio_o`/`div_sel_o` keep their values. The next accepted count clears `err_o`.
- R9: The cycle counter stops at 2047. While measurement is running, a counter at 2047 sets `err_o` and clears `locked_o` on the next cycle.
- R10: Any change in `{speed_i, div_en_i}` clears `locked_o` and `err_o` on the next cycle and restarts measurement. If a rising edge falls in the same cycle as the change, that edge is ignored.
- R11: After reset `ratio_o`=15, `div_sel_o`=0, and `locked_o` and `err_o` are 0.
- R12: `speed_i`=3 is reserved, and every evaluated count under it is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_i | input | 1 | Frame clock sampled in the master domain |
| speed_i | input | 2 | Speed band: 0 single, 1 double, 2 quad, 3 reserved |
| div_en_i | input | 1 | Enables the 4x ratio of the band |
| ratio_o | output | 4 | Locked ratio code (15 = none) |
| div_sel_o | output | 3 | Divider select relative to the band's smallest ratio |
| locked_o | output | 1 | Two equal accepted counts seen |
| err_o | output | 1 | Count not accepted, or counter saturated |

## Verification
Two functions can fall in the same cycle: a mode change and a frame rising edge. The bench forces this by switching `speed_i` on the same clock in which `fclk_i` goes high. It then expects the change to take priority, so the edge neither arms measurement nor is evaluated, and lock is reached only two full periods after the next edge. The end of a saturated stall meets a rising edge in the same way. There the edge takes priority, and the 2047 count it ends is judged as an error.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
  localparam int unsigned NUM_RATIOS = 9;
  localparam logic [3:0]  RATIO_NONE = 4'hF;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;

  // even codes: powers of two of min; odd codes: 1.5x of the code below
  function automatic int unsigned ladder(int unsigned min_ratio, int unsigned k);
    if (k % 2 == 0) return min_ratio << (k / 2);
    return ((3 * min_ratio) / 2) << (k / 2);
  endfunction
endpackage

// File: rtl/rd_counter.sv
module rd_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fclk_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic fclk_q;

  assign rise_o = fclk_i & ~fclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q <= 1'b0;
      cnt_o  <= '0;
    end else begin
      fclk_q <= fclk_i;
      if (rise_o)                cnt_o <= CNT_W'(1);
      else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_cnt_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !rise_o) |=> (cnt_o == CNT_MAX))
    else $error("counter wrapped");
endmodule

// File: rtl/rd_decoder.sv
module rd_decoder
  import ratio_det_pkg::*;
#(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned MIN_RATIO = 64
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       speed_i,
  input  logic             div_en_i,
  output logic             valid_o,
  output logic [3:0]       ratio_o,
  output logic [2:0]       div_sel_o
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_cmp
    assign hit[k] = (cnt_i == CNT_W'(ladder(MIN_RATIO, k)));
  end

  logic [3:0] idx, base, off;
  logic       band_ok;

  always_comb begin
    idx = RATIO_NONE;
    for (int k = 0; k < NUM_RATIOS; k++)
      if (hit[k]) idx = 4'(k);
    band_ok = 1'b1;
    case (speed_e'(speed_i))
      SPD_SINGLE: base = 4'd4;
      SPD_DOUBLE: base = 4'd2;
      SPD_QUAD:   base = 4'd0;
      default: begin base = 4'd0; band_ok = 1'b0; end
    endcase
    off     = idx - base;
    valid_o = band_ok && (idx != RATIO_NONE) && (idx >= base) &&
              ((off <= 4'd3) || (off == 4'd4 && div_en_i));
    ratio_o   = idx;
    div_sel_o = off[2:0];
  end

  always_comb begin
    if (valid_o && div_sel_o == 3'd4)
      p_div4_needs_en_r5: assert (div_en_i) else $error("4x accepted without enable");
  end
endmodule

// File: rtl/rd_lock_ctrl.sv
module rd_lock_ctrl #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       speed_i,
  input  logic             div_en_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             valid_i,
  input  logic [3:0]       ratio_i,
  input  logic [2:0]       div_sel_i,
  output logic [3:0]       ratio_o,
  output logic [2:0]       div_sel_o,
  output logic             locked_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       mode_q;
  logic             armed, prev_ok;
  logic [CNT_W-1:0] prev_cnt;
  logic             chg;

  assign chg = ({speed_i, div_en_i} != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      armed     <= 1'b0;
      prev_ok   <= 1'b0;
      prev_cnt  <= '0;
      ratio_o   <= 4'hF;
      div_sel_o <= '0;
      locked_o  <= 1'b0;
      err_o     <= 1'b0;
    end else if (chg) begin
      mode_q   <= {speed_i, div_en_i};
      armed    <= 1'b0;
      prev_ok  <= 1'b0;
      locked_o <= 1'b0;
      err_o    <= 1'b0;
    end else if (rise_i) begin
      if (!armed) begin
        armed <= 1'b1;
      end else if (!valid_i) begin
        err_o    <= 1'b1;
        locked_o <= 1'b0;
        prev_ok  <= 1'b0;
      end else begin
        err_o <= 1'b0;
        if (prev_ok && cnt_i == prev_cnt) begin
          locked_o  <= 1'b1;
          ratio_o   <= ratio_i;
          div_sel_o <= div_sel_i;
        end else begin
          locked_o <= 1'b0;
          prev_ok  <= 1'b1;
          prev_cnt <= cnt_i;
        end
      end
    end else if (armed && cnt_i == CNT_MAX) begin
      err_o    <= 1'b1;
      locked_o <= 1'b0;
      prev_ok  <= 1'b0;
    end
  end

  p_lock_excl_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !err_o) else $error("locked with error");

  p_err_holds_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($stable(div_sel_o) && $stable(ratio_o)))
    else $error("select moved on error");

  p_chg_unlock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (!locked_o && !err_o)) else $error("mode change kept state");

  p_lock_on_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(rise_i) && $past(valid_i)))
    else $error("lock without accepted edge");
endmodule

// File: rtl/ratio_detect.sv
module ratio_detect #(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned MIN_RATIO = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fclk_i,
  input  logic [1:0] speed_i,
  input  logic       div_en_i,
  output logic [3:0] ratio_o,
  output logic [2:0] div_sel_o,
  output logic       locked_o,
  output logic       err_o
);
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic             dec_valid;
  logic [3:0]       dec_ratio;
  logic [2:0]       dec_div;

  rd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .fclk_i(fclk_i),
    .rise_o(rise), .cnt_o(cnt)
  );

  rd_decoder #(.CNT_W(CNT_W), .MIN_RATIO(MIN_RATIO)) u_dec (
    .cnt_i(cnt), .speed_i(speed_i), .div_en_i(div_en_i),
    .valid_o(dec_valid), .ratio_o(dec_ratio), .div_sel_o(dec_div)
  );

  rd_lock_ctrl #(.CNT_W(CNT_W)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .speed_i(speed_i), .div_en_i(div_en_i),
    .rise_i(rise), .cnt_i(cnt), .valid_i(dec_valid), .ratio_i(dec_ratio),
    .div_sel_i(dec_div), .ratio_o(ratio_o), .div_sel_o(div_sel_o),
    .locked_o(locked_o), .err_o(err_o)
  );
endmodule

// File: tb/ratio_detect_test.sv
`timescale 1ns/1ps
module ratio_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fclk = 1'b0;
  logic [1:0] speed = 2'd0;
  logic       div_en = 1'b0;
  logic [3:0] ratio;
  logic [2:0] div_sel;
  logic       locked, err;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  always #10 clk = ~clk;

  ratio_detect uut (
    .clk_i(clk), .rst_ni(rst_n), .fclk_i(fclk), .speed_i(speed),
    .div_en_i(div_en), .ratio_o(ratio), .div_sel_o(div_sel),
    .locked_o(locked), .err_o(err)
  );

  // behavioural reference
  int lad[9] = '{64, 96, 128, 192, 256, 384, 512, 768, 1024};
  int m_cnt, m_prev, m_mode, m_ratio, m_div;
  bit m_fq, m_armed, m_pok, m_locked, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev = 0; m_mode = 0; m_ratio = 15; m_div = 0;
      m_fq = 0; m_armed = 0; m_pok = 0; m_locked = 0; m_err = 0;
    end else begin
      int c, k, base, off, mode;
      bit rise, ok;
      c = m_cnt;
      rise = fclk && !m_fq;
      m_fq = fclk;
      if (rise) m_cnt = 1; else if (m_cnt < 2047) m_cnt = m_cnt + 1;
      k = -1;
      foreach (lad[i]) if (lad[i] == c) k = i;
      base = (speed == 2'd0) ? 4 : (speed == 2'd1) ? 2 : (speed == 2'd2) ? 0 : -1;
      off = k - base;
      ok = (base >= 0) && (k >= 0) && (off >= 0) && (off <= 3 || (off == 4 && div_en));
      mode = {speed, div_en};
      if (mode != m_mode) begin
        m_mode = mode; m_armed = 0; m_pok = 0; m_locked = 0; m_err = 0;
      end else if (rise) begin
        if (!m_armed) m_armed = 1;
        else if (!ok) begin m_err = 1; m_locked = 0; m_pok = 0; end
        else begin
          m_err = 0;
          if (m_pok && c == m_prev) begin m_locked = 1; m_ratio = k; m_div = off; end
          else begin m_locked = 0; m_pok = 1; m_prev = c; end
        end
      end else if (m_armed && c == 2047) begin
        m_err = 1; m_locked = 0; m_pok = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (ratio !== 4'(m_ratio) || div_sel !== 3'(m_div) ||
          locked !== m_locked || err !== m_err) begin
        n_bad++;
        $display("FAIL %s t=%0t ratio/div/lock/err act=%0d/%0d/%0b/%0b exp=%0d/%0d/%0b/%0b",
                 cur_req, $time, ratio, div_sel, locked, err, m_ratio, m_div, m_locked, m_err);
      end
    end
  end

  task automatic frames(int n, int cnt, int sp = -1, int de = -1);
    for (int f = 0; f < cnt; f++)
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        if (f == 0 && i == 0 && sp >= 0) begin speed = 2'(sp); div_en = de[0]; end
        fclk = (i < n / 2);
      end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); fclk = 1'b0; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;  // R11 reset values
    if (ratio !== 4'hF || div_sel !== 3'd0 || locked !== 1'b0 || err !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset act=%0d/%0d/%0b/%0b exp=15/0/0/0", ratio, div_sel, locked, err);
    end
    cur_req = "R6";  frames(256, 2);
    cur_req = "R1";  frames(256, 2);
    cur_req = "R2";  frames(384, 3); frames(512, 3); frames(768, 3);
    cur_req = "R5";  frames(1024, 2); frames(1024, 4, 0, 1);
    cur_req = "R3";  frames(128, 3, 1, 0); frames(192, 3); frames(256, 3); frames(384, 3); frames(512, 2);
    cur_req = "R5";  frames(512, 3, 1, 1);
    cur_req = "R4";  frames(64, 3, 2, 0); frames(96, 3); frames(128, 3); frames(192, 3); frames(256, 2);
    cur_req = "R8";  frames(300, 3, 0, 0); frames(256, 3);
    cur_req = "R7";  frames(384, 1); frames(256, 1); frames(384, 3);
    cur_req = "R9";  idle(2300); frames(256, 4);
    cur_req = "R10"; frames(128, 1); frames(192, 3, 1, 0); frames(192, 2);
    idle(50); speed = 2'd2; frames(96, 3); frames(256, 3, 0, 0);
    cur_req = "R12"; frames(256, 4, 3, 0);
    idle(5);
    finish_run();
  end
endmodule